// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. The arithmetic is done by an array of N adder rows. Each row is made of gated full-adder cells, and one multiplier bit selects whether the row adds the multiplicand to the running sum or only passes that sum on with its carries. Every row is followed by a register, so each row is its own pipeline stage. The multiplicand and the multiplier bits not yet consumed travel down the pipe beside their partial sum, so many products can be in flight at once.

A pair of operands is offered together with a valid flag. The pipe never stalls. A fresh pair may enter on every clock, and each result leaves after exactly N rising edges with its own valid flag. Each row retires one low product bit, and that bit is shifted into a per-stage result register. After the last row the upper half of the product is the running sum and the lower half is that shifted register.

Top module: `pipe_array_mul`

## Requirements
- R1: When out_valid_o is 1, product_o equals the unsigned product a_i*b_i of the pair that entered with it, taken as 2N bits with no truncation.
- R2: A pair sampled with in_valid_i=1 at a rising edge appears on product_o right after the N-th rising edge, counting the sampling edge as the first.
- R3: A new pair may be presented on every cycle. Back-to-back pairs with different operands each yield their own correct product on consecutive cycles.
- R4: out_valid_o is in_valid_i delayed by exactly N cycles, so gaps in the input stream appear as out_valid_o=0 at the output.
- R5: While rst_ni is 0, out_valid_o is 0. After reset is released, out_valid_o stays 0 until a valid pair sampled after the release has travelled the whole pipe. Pairs in flight when reset is asserted are lost.
- R6: A zero operand on either side gives a zero product. Two all-ones operands give (2^N-1)^2, which has bit 0 set, bits 1 to N set to 0 and the top N-1 bits set to 1.
- R7: A multiplier row whose bit is 0 adds nothing. A multiplier with only bit i set returns the multiplicand shifted left by i, and a multiplier of 1 returns the multiplicand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair on a_i/b_i is valid this cycle |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| out_valid_o | output | 1 | product_o holds a valid result |
| product_o | output | 2N | Unsigned product |

## Verification
The two functions that overlap are taking in a new operand pair and delivering an older product, and once the pipe is full they happen in every cycle. To provoke the overlap, the bench sends unbroken streams of random operands and streams with random valid gaps, so that bubbles and live data sit in neighbouring stages. The bench also asserts reset while the pipe is full. A behavioural delay-line model, built from a queue and the plain `*` operator, predicts out_valid_o and product_o for every cycle and is compared with the outputs on each falling edge.

// File: rtl/arr_mul_pkg.sv
package arr_mul_pkg;
  function automatic int unsigned prod_width(input int unsigned n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/gated_fa_cell.sv
module gated_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic addend;
  assign addend     = x_i & z_i;
  assign {c_o, s_o} = {1'b0, y_i} + {1'b0, addend} + {1'b0, c_i};
endmodule

// File: rtl/gated_add_row.sv
module gated_add_row #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] sum_i,
  input  logic         sel_i,
  output logic [N:0]   res_o
);
  logic [N:0]   carry;
  logic [N-1:0] bit_sum;

  assign carry[0] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_cell
    gated_fa_cell u_cell (
      .x_i (mcand_i[j]),
      .y_i (sum_i[j]),
      .z_i (sel_i),
      .c_i (carry[j]),
      .s_o (bit_sum[j]),
      .c_o (carry[j+1])
    );
  end

  assign res_o = {carry[N], bit_sum};
endmodule

// File: rtl/mul_pipe_stage.sv
module mul_pipe_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] lo_i,
  output logic         valid_o,
  output logic [N-1:0] mcand_o,
  output logic [N-1:0] mplier_o,
  output logic [N-1:0] acc_o,
  output logic [N-1:0] lo_o
);
  logic [N:0] row_res;

  gated_add_row #(.N(N)) u_row (
    .mcand_i (mcand_i),
    .sum_i   (acc_i),
    .sel_i   (mplier_i[0]),
    .res_o   (row_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      mcand_o  <= '0;
      mplier_o <= '0;
      acc_o    <= '0;
      lo_o     <= '0;
    end else begin
      valid_o  <= valid_i;
      mcand_o  <= mcand_i;
      mplier_o <= mplier_i >> 1;
      acc_o    <= row_res[N:1];
      // retired bit enters at the top; after N rows it reaches bit 0
      lo_o     <= (lo_i >> 1) | (N'(row_res[0]) << (N - 1));
    end
  end

  // first edge after reset has no post-reset history
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_valid_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    valid_o == $past(valid_i));

  assert_mcand_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    mcand_o == $past(mcand_i));

  assert_mplier_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    mplier_o == ($past(mplier_i) >> 1));

  assert_row_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    {acc_o, lo_o[N-1]} == ({1'b0, $past(acc_i)} +
                           ($past(mplier_i[0]) ? {1'b0, $past(mcand_i)} : {(N+1){1'b0}})));
endmodule

// File: rtl/pipe_array_mul.sv
module pipe_array_mul
  import arr_mul_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [N-1:0]      a_i,
  input  logic [N-1:0]      b_i,
  output logic              out_valid_o,
  output logic [2*N-1:0]    product_o
);
  localparam int unsigned PW = prod_width(N);

  logic [N:0]        valid_s;
  logic [N:0][N-1:0] mcand_s;
  logic [N:0][N-1:0] mplier_s;
  logic [N:0][N-1:0] acc_s;
  logic [N:0][N-1:0] lo_s;

  assign valid_s[0]  = in_valid_i;
  assign mcand_s[0]  = a_i;
  assign mplier_s[0] = b_i;
  assign acc_s[0]    = '0;
  assign lo_s[0]     = '0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    mul_pipe_stage #(.N(N)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_s[k]),
      .mcand_i  (mcand_s[k]),
      .mplier_i (mplier_s[k]),
      .acc_i    (acc_s[k]),
      .lo_i     (lo_s[k]),
      .valid_o  (valid_s[k+1]),
      .mcand_o  (mcand_s[k+1]),
      .mplier_o (mplier_s[k+1]),
      .acc_o    (acc_s[k+1]),
      .lo_o     (lo_s[k+1])
    );
  end

  assign out_valid_o = valid_s[N];
  assign product_o   = PW'({acc_s[N], lo_s[N]});

  // all multiplier bits must be consumed by the last row
  assert_mplier_drained_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> mplier_s[N] == '0);
endmodule

// File: tb/pipe_array_mul_tb_top.sv
module pipe_array_mul_tb_top;
  localparam int unsigned N = 8;
  localparam int unsigned PW = 2 * N;
  localparam time CLK_PERIOD = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [N-1:0]  a_i = '0;
  logic [N-1:0]  b_i = '0;
  logic          out_valid_o;
  logic [PW-1:0] product_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pipe_array_mul #(.N(N)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .product_o   (product_o)
  );

  typedef struct packed {
    logic          v;
    logic [PW-1:0] p;
  } exp_t;

  exp_t q[$];
  exp_t cur = '0;

  // behavioural delay-line model: output appears N edges after sampling
  always @(posedge clk_i) begin
    exp_t e;
    if (!rst_ni) begin
      q.delete();
      for (int i = 0; i < int'(N) - 1; i++) q.push_back('0);
      cur = '0;
    end else begin
      e.v = in_valid_i;
      e.p = PW'(a_i) * PW'(b_i);
      q.push_back(e);
      cur = q.pop_front();
    end
  end

  task automatic check(input string tag);
    total++;
    if (out_valid_o !== cur.v) begin
      bad++;
      $display("FAIL %s: out_valid actual=%0b expected=%0b", tag, out_valid_o, cur.v);
    end else if (cur.v && product_o !== cur.p) begin
      bad++;
      $display("FAIL %s: product actual=%0h expected=%0h", tag, product_o, cur.p);
    end
  endtask

  task automatic cycle(input logic v, input logic [N-1:0] x, input logic [N-1:0] y,
                       input string tag);
    in_valid_i = v; a_i = x; b_i = y;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < int'(N) + 1; i++) cycle(1'b0, '0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R5: valid low while held in reset
    repeat (3) @(negedge clk_i);
    check("R5 reset");
    rst_ni = 1'b1;
    cycle(1'b0, '0, '0, "R5 idle");

    // R2: single pair, watch the exact exit cycle
    cycle(1'b1, 8'd13, 8'd11, "R2 latency");
    for (int i = 0; i < int'(N) + 2; i++) cycle(1'b0, 8'hff, 8'hff, "R2 latency");

    // R6: zero and all-ones corners
    cycle(1'b1, 8'h00, 8'hff, "R6 zero a");
    cycle(1'b1, 8'hff, 8'h00, "R6 zero b");
    cycle(1'b1, 8'hff, 8'hff, "R6 all ones");
    cycle(1'b1, 8'h00, 8'h00, "R6 both zero");
    flush("R6");

    // R7: one-hot multipliers and unit multiplier
    for (int i = 0; i < int'(N); i++) cycle(1'b1, 8'hb5, 8'(1 << i), "R7 onehot");
    cycle(1'b1, 8'h9c, 8'h01, "R7 unit");
    flush("R7");

    // R3 / R1: back-to-back distinct pairs
    for (int i = 0; i < 200; i++) cycle(1'b1, 8'($urandom), 8'($urandom), "R3 stream");
    flush("R3");

    // R4: random gaps
    for (int i = 0; i < 300; i++)
      cycle(1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), "R4 gaps");
    flush("R4");

    // R5: reset with a full pipe drops in-flight pairs
    for (int i = 0; i < int'(N) - 1; i++) cycle(1'b1, 8'($urandom), 8'($urandom), "R5 fill");
    rst_ni = 1'b0;
    #1;
    total++;
    if (out_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R5 async clear: actual=%0b expected=0", out_valid_o);
    end
    cycle(1'b1, 8'h55, 8'h33, "R5 in reset");
    rst_ni = 1'b1;
    for (int i = 0; i < int'(N) + 2; i++) cycle(1'b0, '0, '0, "R5 after release");
    for (int i = 0; i < 50; i++) cycle(1'b1, 8'($urandom), 8'($urandom), "R1 after reset");
    flush("R1");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule